// File: doc/BRIEF.md
# One-Time-Programmable Program Store Programming Port

This block is the device-side logic that an external programmer uses to fill and read back a one-time-programmable byte store of 8064 locations. The programmer never presents an address. It selects an operation on four mode pins, steps a hidden address pointer by toggling an external step clock, and moves each byte through two 4-bit data ports, the low nibble on one and the high nibble on the other.

The pointer advances once for every fourth rising edge seen on the step clock, and a dedicated mode code returns it to location zero. In write mode the byte on the data ports is merged into the current location; because an unprogrammed cell reads as all ones and programming can only pull bits low, the stored value becomes the old value ANDed with the presented data. In verify mode the block drives the stored byte onto the data ports; in every other mode the ports are released. The whole port answers only while a program-enable input is high, which stands in for detection of the programming supply.

The storage is a behavioural byte register file that keeps its contents across the block's reset, as a non-volatile array would.

Top module: `otp_prog_port`

## Requirements
- R1: The mode pins are read as {MD3,MD2,MD1,MD0} = mode_pin[3:0]. Code 4'b0101 is address clear, 4'b1110 is write, 4'b1100 is verify, and 4'b1101 or 4'b1111 is inhibit.
- R2: data_oe is high exactly while prog_en is high and mode_pin is 4'b1100; then data_lo_o carries bits 3:0 and data_hi_o bits 7:4 of the byte at the current location, and while data_oe is low both output nibbles are 0.
- R3: A rising edge of ext_clk is a clock cycle in which ext_clk is 1 after being 0 in the previous cycle; while enabled in any mode other than address clear, every fourth such edge advances the location by one, and three edges leave it unchanged.
- R4: While enabled with code 4'b0101 the location becomes 0 and the edge count restarts, so four further edges are needed for the next step, and edges seen during the clear are discarded.
- R5: A step from the last location 0x1F7F returns to location 0; the location never exceeds 0x1F7F.
- R6: In each clock cycle with prog_en high and mode 4'b1110, the byte at the current location becomes its old value ANDed with {data_hi_i, data_lo_i}.
- R7: Every location reads 0xFF before it is written, and no write can turn a 0 bit back into 1.
- R8: While prog_en is low the data ports are released, the mode pins are ignored, ext_clk edges are not counted and no location changes.
- R9: Inhibit and every code not listed in R1 neither write nor drive the data ports, though step-clock edges still count.
- R10: rst sets the location and the edge count to 0 and leaves the stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the pointer logic |
| prog_en | input | 1 | Programming enable; the port is inert while low |
| mode_pin | input | 4 | Operation select, bit n is mode pin n |
| ext_clk | input | 1 | External step clock, sampled on clk |
| data_lo_i | input | 4 | Low data nibble from the programmer |
| data_hi_i | input | 4 | High data nibble from the programmer |
| data_lo_o | output | 4 | Low data nibble toward the programmer |
| data_hi_o | output | 4 | High data nibble toward the programmer |
| data_oe | output | 1 | Output enable for both data nibbles |

## Verification
The bench builds the block with its default parameters: the full 8064-location store, a last location of 0x1F7F and four edges per step. With those values the whole address space is walkable inside the run, so the step from 0x1F7F back to 0 is checked against a byte written at the very last location, next to the partial-step, clear-mid-count, disabled-port and reset-retention cases on the low addresses.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    // Raw mode-pin codes, bit n = mode pin n
    localparam logic [3:0] MODE_CLEAR  = 4'b0101;
    localparam logic [3:0] MODE_WRITE  = 4'b1110;
    localparam logic [3:0] MODE_VERIFY = 4'b1100;

    typedef enum logic [2:0] {
        OP_OFF     = 3'd0,   // port disabled
        OP_CLEAR   = 3'd1,
        OP_WRITE   = 3'd2,
        OP_VERIFY  = 3'd3,
        OP_INHIBIT = 3'd4
    } prog_op_e;

    typedef struct packed {
        logic [3:0] hi;
        logic [3:0] lo;
    } nib_pair_t;

    function automatic prog_op_e decode_mode(input logic [3:0] pins);
        prog_op_e op;
        case (pins)
            MODE_CLEAR:  op = OP_CLEAR;
            MODE_WRITE:  op = OP_WRITE;
            MODE_VERIFY: op = OP_VERIFY;
            default:     op = OP_INHIBIT;   // explicit inhibit and unused codes
        endcase
        return op;
    endfunction

    function automatic logic op_counts_edges(input prog_op_e op);
        return (op != OP_OFF) && (op != OP_CLEAR);
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_prog_pkg::*;
(
    input  logic       prog_en,
    input  logic [3:0] mode_pin,
    output prog_op_e   op
);
    always_comb begin
        if (prog_en) op = decode_mode(mode_pin);
        else         op = OP_OFF;
    end
endmodule

// File: rtl/otp_addr_seq.sv
module otp_addr_seq
    import otp_prog_pkg::*;
#(
    parameter int LAST_ADDR      = 8063,
    parameter int EDGES_PER_STEP = 4,
    localparam int ADDR_W = $clog2(LAST_ADDR + 1),
    localparam int CNT_W  = (EDGES_PER_STEP > 1) ? $clog2(EDGES_PER_STEP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  prog_op_e          op,
    input  logic              ext_clk,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(LAST_ADDR);
    localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(EDGES_PER_STEP - 1);

    logic             ext_q;
    logic             ext_rise;
    logic [CNT_W-1:0] edge_cnt;

    assign ext_rise = ext_clk & ~ext_q;

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_clk;
    end

    always_ff @(posedge clk) begin
        if (rst || op == OP_CLEAR) begin
            addr     <= '0;
            edge_cnt <= '0;
        end else if (op_counts_edges(op) && ext_rise) begin
            if (edge_cnt == CNT_TOP) begin
                edge_cnt <= '0;
                addr     <= (addr == ADDR_TOP) ? '0 : addr + 1'b1;
            end else begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_prog_pkg::*;
#(
    parameter int WORDS = 8064,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] addr,
    input  nib_pair_t         wdata,
    output nib_pair_t         rdata
);
    logic [7:0] cells [WORDS];

    // Unprogrammed die: every cell holds all ones
    initial begin
        for (int i = 0; i < WORDS; i++) cells[i] = 8'hFF;
    end

    // Programming only clears bits
    always_ff @(posedge clk) begin
        if (prog_we) cells[addr] <= cells[addr] & wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
    import otp_prog_pkg::*;
#(
    parameter int LAST_ADDR      = 8063,
    parameter int EDGES_PER_STEP = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prog_en,
    input  logic [3:0] mode_pin,
    input  logic       ext_clk,
    input  logic [3:0] data_lo_i,
    input  logic [3:0] data_hi_i,
    output logic [3:0] data_lo_o,
    output logic [3:0] data_hi_o,
    output logic       data_oe
);
    localparam int WORDS  = LAST_ADDR + 1;
    localparam int ADDR_W = $clog2(WORDS);

    prog_op_e          op;
    logic [ADDR_W-1:0] cur_addr;
    nib_pair_t         wr_byte;
    nib_pair_t         rd_byte;
    logic              drive;

    otp_mode_decode u_dec (
        .prog_en  (prog_en),
        .mode_pin (mode_pin),
        .op       (op)
    );

    otp_addr_seq #(
        .LAST_ADDR      (LAST_ADDR),
        .EDGES_PER_STEP (EDGES_PER_STEP)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ext_clk (ext_clk),
        .addr    (cur_addr)
    );

    assign wr_byte = '{hi: data_hi_i, lo: data_lo_i};

    otp_cell_array #(
        .WORDS (WORDS)
    ) u_cells (
        .clk     (clk),
        .prog_we (op == OP_WRITE),
        .addr    (cur_addr),
        .wdata   (wr_byte),
        .rdata   (rd_byte)
    );

    assign drive     = (op == OP_VERIFY);
    assign data_oe   = drive;
    assign data_lo_o = drive ? rd_byte.lo : 4'h0;
    assign data_hi_o = drive ? rd_byte.hi : 4'h0;
endmodule

// File: rtl/otp_prog_port_chk.sv
module otp_prog_port_chk #(
    parameter int LAST_ADDR = 8063,
    localparam int ADDR_W = $clog2(LAST_ADDR + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              prog_en,
    input logic [3:0]        mode_pin,
    input logic [3:0]        data_lo_o,
    input logic [3:0]        data_hi_o,
    input logic              data_oe,
    input logic [ADDR_W-1:0] cur_addr
);
    assert_oe_only_verify_R2: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (prog_en && mode_pin == 4'b1100));

    assert_released_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_lo_o == 4'h0 && data_hi_o == 4'h0));

    assert_disabled_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !prog_en |=> $stable(cur_addr));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (prog_en && mode_pin == 4'b0101) |=> cur_addr == '0);

    assert_step_or_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_addr) |-> (cur_addr == $past(cur_addr) + 1'b1 || cur_addr == '0));

    assert_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        cur_addr <= ADDR_W'(LAST_ADDR));

    assert_reset_zero_R10: assert property (@(posedge clk)
        rst |=> cur_addr == '0);
endmodule

bind otp_prog_port otp_prog_port_chk #(.LAST_ADDR(LAST_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .prog_en   (prog_en),
    .mode_pin  (mode_pin),
    .data_lo_o (data_lo_o),
    .data_hi_o (data_hi_o),
    .data_oe   (data_oe),
    .cur_addr  (cur_addr)
);

// File: tb/sim_otp_prog_port.sv
`timescale 1ns/1ps
module sim_otp_prog_port;
    localparam int LAST = 8063;
    localparam logic [3:0] M_CLR = 4'b0101;
    localparam logic [3:0] M_WR  = 4'b1110;
    localparam logic [3:0] M_VER = 4'b1100;
    localparam logic [3:0] M_INH = 4'b1101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_en = 1'b0;
    logic [3:0] mode_pin = 4'b0000;
    logic ext_clk = 1'b0;
    logic [3:0] data_lo_i = 4'h0;
    logic [3:0] data_hi_i = 4'h0;
    logic [3:0] data_lo_o;
    logic [3:0] data_hi_o;
    logic data_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    otp_prog_port u0 (
        .clk(clk), .rst(rst), .prog_en(prog_en), .mode_pin(mode_pin),
        .ext_clk(ext_clk), .data_lo_i(data_lo_i), .data_hi_i(data_hi_i),
        .data_lo_o(data_lo_o), .data_hi_o(data_hi_o), .data_oe(data_oe)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] ref_mem [0:LAST];
    int ref_addr = 0;
    int ref_cnt = 0;
    bit ref_prev = 1'b0;
    initial for (int i = 0; i <= LAST; i++) ref_mem[i] = 8'hFF;

    always @(posedge clk) begin
        if (rst) begin
            ref_addr = 0; ref_cnt = 0; ref_prev = 1'b0;
        end else begin
            if (prog_en) begin
                if (mode_pin == M_WR)
                    ref_mem[ref_addr] = ref_mem[ref_addr] & {data_hi_i, data_lo_i};
                if (mode_pin == M_CLR) begin
                    ref_addr = 0; ref_cnt = 0;
                end else if (ext_clk && !ref_prev) begin
                    ref_cnt++;
                    if (ref_cnt == 4) begin
                        ref_cnt = 0;
                        ref_addr = (ref_addr == LAST) ? 0 : ref_addr + 1;
                    end
                end
            end
            ref_prev = ext_clk;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic eoe;
            logic [7:0] ed;
            eoe = prog_en && (mode_pin == M_VER);
            ed  = eoe ? ref_mem[ref_addr] : 8'h00;
            check("R2 oe vs model", data_oe, eoe);
            check("R2 data vs model", {data_hi_o, data_lo_o}, ed);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #2;
    endtask
    task automatic set_mode(input logic [3:0] m);
        mode_pin = m; tick();
    endtask
    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; tick();
            ext_clk = 1'b0; tick();
        end
    endtask
    task automatic write_byte(input logic [7:0] b);
        {data_hi_i, data_lo_i} = b;
        set_mode(M_WR);
        set_mode(M_INH);
    endtask
    task automatic sample(output logic [7:0] b, output logic oe);
        @(negedge clk);
        b = {data_hi_o, data_lo_o};
        oe = data_oe;
        #2;
    endtask
    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 8'hFE);
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] b;
        logic oe;
        repeat (5) tick();
        sample(b, oe);
        check("R10 reset oe", oe, 0);
        check("R2 released outputs zero", b, 8'h00);
        rst = 1'b0;
        prog_en = 1'b1;

        set_mode(M_CLR);
        set_mode(M_VER);
        sample(b, oe);
        check("R7 erased reads FF", b, 8'hFF);
        check("R2 oe in verify", oe, 1);

        // R1 R6: program addresses 0..5
        set_mode(M_CLR);
        set_mode(M_INH);
        for (int a = 0; a < 6; a++) begin
            write_byte(pat(a));
            pulses(4);
        end
        set_mode(M_CLR);
        set_mode(M_VER);
        // R3: three edges keep the location, the fourth steps it
        pulses(3);
        sample(b, oe);
        check("R3 three edges hold", b, pat(0));
        pulses(1);
        sample(b, oe);
        check("R3 fourth edge steps", b, pat(1));
        set_mode(M_CLR);
        set_mode(M_VER);
        for (int a = 0; a < 6; a++) begin
            sample(b, oe);
            check("R6 readback", b, pat(a));
            pulses(4);
        end

        // R6 R7: AND merge at location 10
        set_mode(M_CLR);
        set_mode(M_INH);
        pulses(40);
        write_byte(8'hF0);
        write_byte(8'h3C);
        set_mode(M_VER);
        sample(b, oe);
        check("R6 and merge", b, 8'h30);
        set_mode(M_INH);
        write_byte(8'hFF);
        set_mode(M_VER);
        sample(b, oe);
        check("R7 no bit set", b, 8'h30);

        // R8: disabled port
        prog_en = 1'b0;
        sample(b, oe);
        check("R8 released while disabled", oe, 0);
        {data_hi_i, data_lo_i} = 8'h00;
        set_mode(M_WR);
        tick();
        pulses(8);
        set_mode(M_CLR);
        prog_en = 1'b1;
        set_mode(M_VER);
        sample(b, oe);
        check("R8 nothing changed", b, 8'h30);

        // R9: inhibit codes and unused codes with zero data
        set_mode(4'b1101);
        set_mode(4'b1111);
        set_mode(4'b0000);
        sample(b, oe);
        check("R9 unused code no drive", oe, 0);
        set_mode(4'b1010);
        set_mode(4'b0110);
        set_mode(M_VER);
        sample(b, oe);
        check("R9 no write", b, 8'h30);
        set_mode(4'b0000);
        pulses(4);
        set_mode(M_VER);
        sample(b, oe);
        check("R9 edges counted", b, 8'hFF);

        // R4: clear restarts the edge count and discards edges
        pulses(2);
        set_mode(M_CLR);
        pulses(4);
        set_mode(M_INH);
        pulses(2);
        set_mode(M_VER);
        sample(b, oe);
        check("R4 clear restarts count", b, pat(0));
        pulses(2);
        sample(b, oe);
        check("R4 four edges after clear", b, pat(1));

        // R10: reset returns to 0 and keeps contents
        pulses(8);
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        sample(b, oe);
        check("R10 location zero kept", b, pat(0));
        pulses(4);
        sample(b, oe);
        check("R10 contents kept", b, pat(1));

        // R5: walk to the last location and wrap
        set_mode(M_CLR);
        set_mode(M_INH);
        for (int a = 0; a < LAST; a++) pulses(4);
        set_mode(M_VER);
        sample(b, oe);
        check("R5 last erased", b, 8'hFF);
        set_mode(M_INH);
        write_byte(8'h11);
        set_mode(M_VER);
        sample(b, oe);
        check("R5 last written", b, 8'h11);
        pulses(4);
        sample(b, oe);
        check("R5 wrap to zero", b, pat(0));

        set_mode(M_INH);
        prog_en = 1'b0;
        tick();
        finish_run();
    end
endmodule